// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block collects up to eight hardware interrupt lines, holds each one as a pending request, and drops any request whose line is masked. It then picks a single winner and drives one interrupt output to the processor. A winner is forwarded only if it outranks everything currently marked as being serviced. When the processor acknowledges, the block latches a vector onto its read-data port. The vector is a programmed base plus the winning line number. At the same time the block moves the winner from the pending set into the in-service set.

The host reaches the block through a small register port: a select, read and write strobes, one address bit and byte-wide data. Address 0 accepts command bytes. These switch the sensing mode, auto-completion and rotating priority, load the vector base, signal end of service, and choose which status register an address-0 read returns. Address 1 reads and writes the mask. An acknowledge that arrives after the request has vanished is answered as spurious.

Top module: `irq_ctl8`

## Requirements
- R1: After reset the mask, pending and in-service registers read zero, `int_out` is low, priority is fixed, sensing is edge, auto-completion is off, the vector base is 0 and address-0 reads return the pending register.
- R2: In edge mode a low-to-high transition on `irq_in[n]` sets pending bit n on the next clock edge. A steady high level sets nothing further. An acknowledge that services line n clears pending bit n.
- R3: Command byte 0x10 with bit 0 set selects level mode. In that mode the pending register copies `irq_in` one clock later, and an acknowledge does not clear it.
- R4: A write to address 1 loads the mask and a read from address 1 returns it. A pending line whose mask bit is 1 never raises `int_out`.
- R5: In fixed priority line 0 ranks highest and line 7 lowest. `int_out` is high only if an unmasked pending line ranks strictly above every in-service line.
- R6: A command byte with bit 7 set loads the vector base as its bits 4:0 followed by three zero bits. A valid acknowledge returns base plus the winning line on `bus_rdata`, one clock after the acknowledge edge.
- R7: If `int_out` is low when `int_ack` is sampled, the returned vector is base plus 7 and the in-service register is unchanged.
- R8: Command 0x0A selects the pending register and 0x0B selects the in-service register for later address-0 reads.
- R9: Command 0x20 clears the highest-ranked in-service bit. Commands 0x60 to 0x67 clear in-service bit n, where n is the low three bits of the command.
- R10: Command byte 0x10 with bit 1 set enables auto-completion. A valid acknowledge then leaves the in-service register unchanged.
- R11: Command byte 0x10 with bit 2 set selects rotating priority. The line whose service has just completed becomes the lowest rank, and the line after it becomes the highest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register port select |
| bus_rd | input | 1 | Read strobe, data latched at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = command / status, 1 = mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data or acknowledge vector |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Processor acknowledge, one cycle per acknowledge |

## Verification
The bound checker watches several rules on every clock:
- `int_out` is never raised while every pending line is masked.
- A spurious acknowledge never changes the in-service set and always returns line 7's vector.
- A valid acknowledge adds exactly one in-service bit, or none under auto-completion.
- In level mode the pending register follows the inputs with one cycle of delay.

The bench's scenarios show the behaviours that depend on history:
- Nesting order under fixed priority.
- Which bit a non-specific completion clears.
- How the rank order moves after completions in rotating mode.
- That a steady high level in edge mode does not re-request.

// File: rtl/irq_ctl8_pkg.sv
// Package: command encodings shared by the controller and its checker.
// Assumes byte-wide host data.
package irq_ctl8_pkg;
    localparam int DW = 8;
    localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
    localparam logic [7:0] CMD_NS_EOI  = 8'h20;
    localparam logic [4:0] CMD_MODE_HI = 5'b00010;   // 0x10..0x17
    localparam logic [4:0] CMD_SEOI_HI = 5'b01100;   // 0x60..0x67

    // Mode fields carried by a 0x10..0x17 command byte.
    typedef struct packed {
        logic rotate;
        logic auto_eoi;
        logic level;
    } mode_t;
endpackage

// File: rtl/irq_ctl8_req_latch.sv
// Request latch: holds the pending register.
// Edge mode sets a bit on a rising input and clears it on request.
// Level mode copies the inputs.
// Assumes irq_in is already synchronous to clk.
module irq_ctl8_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev_q;

    // Track previous input levels and update pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr    <= '0;
        end else begin
            prev_q <= irq_in;
            if (level_mode)
                irr <= irq_in;
            else
                irr <= (irr & ~clr_vec) | (irq_in & ~prev_q);
        end
    end
endmodule

// File: rtl/irq_ctl8_resolver.sv
// Priority resolver, purely combinational.
// It finds the highest-ranked pending line and the highest-ranked in-service line.
// It requests an interrupt when the pending winner strictly outranks service.
// Rank 0 belongs to line `start`. Assumes N is a power of two, so index arithmetic wraps.
module irq_ctl8_resolver #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] isr,
    input  logic [W-1:0] start,
    output logic         cand_vld,
    output logic [W-1:0] cand,
    output logic         isr_any,
    output logic [W-1:0] isr_top,
    output logic         int_req
);
    logic [W-1:0] cand_rank;
    logic [W-1:0] isr_rank;

    // Scan from lowest rank to highest so the last hit is the winner.
    always_comb begin
        cand_vld = 1'b0;
        cand     = '0;
        isr_any  = 1'b0;
        isr_top  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[start + W'(i)]) begin
                cand_vld = 1'b1;
                cand     = start + W'(i);
            end
            if (isr[start + W'(i)]) begin
                isr_any = 1'b1;
                isr_top = start + W'(i);
            end
        end
    end

    // Compare ranks relative to the current top-priority line.
    always_comb begin
        cand_rank = cand - start;
        isr_rank  = isr_top - start;
        int_req   = cand_vld && (!isr_any || (cand_rank < isr_rank));
    end
endmodule

// File: rtl/irq_ctl8.sv
// Eight-line interrupt controller top.
// It decodes host commands, holds mask, mode, base and in-service state,
// and answers acknowledges with vectors.
// Assumes single-cycle strobes, synchronous to clk.
module irq_ctl8
    import irq_ctl8_pkg::*;
#(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  irq_in,
    output logic          int_out,
    input  logic          int_ack
);
    logic [N-1:0]  irr_q, isr_q, mask_q, isr_next, irr_clr;
    logic [DW-1:0] base_q;
    mode_t         mode_q;
    logic          sel_isr_q;
    logic [W-1:0]  low_ptr_q, start, cand, isr_top, eoi_line;
    logic          cand_vld, isr_any, int_req, eoi_do, ack_ok;
    logic          wr_cmd, wr_mask, rd_en;

    assign wr_cmd  = bus_sel & bus_wr & ~bus_addr;
    assign wr_mask = bus_sel & bus_wr & bus_addr;
    assign rd_en   = bus_sel & bus_rd;
    assign start   = mode_q.rotate ? low_ptr_q + 1'b1 : '0;
    assign ack_ok  = int_ack & int_req;
    assign int_out = int_req;

    irq_ctl8_req_latch #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .level_mode(mode_q.level),
        .irq_in(irq_in), .clr_vec(irr_clr), .irr(irr_q)
    );

    irq_ctl8_resolver #(.N(N)) u_res (
        .pend(irr_q & ~mask_q), .isr(isr_q), .start(start),
        .cand_vld(cand_vld), .cand(cand), .isr_any(isr_any),
        .isr_top(isr_top), .int_req(int_req)
    );

    // Decode completion commands and form the next in-service set.
    always_comb begin
        eoi_do   = 1'b0;
        eoi_line = '0;
        if (wr_cmd && bus_wdata == CMD_NS_EOI && isr_any) begin
            eoi_do   = 1'b1;
            eoi_line = isr_top;
        end else if (wr_cmd && bus_wdata[7:3] == CMD_SEOI_HI) begin
            eoi_do   = 1'b1;
            eoi_line = bus_wdata[W-1:0];
        end
        irr_clr  = ack_ok ? (N'(1) << cand) : '0;
        isr_next = isr_q & ~(eoi_do ? (N'(1) << eoi_line) : '0);
        if (ack_ok && !mode_q.auto_eoi)
            isr_next = isr_next | (N'(1) << cand);
    end

    // Control and state registers written by the host or by acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q     <= '0;
            mask_q    <= '0;
            base_q    <= '0;
            mode_q    <= '0;
            sel_isr_q <= 1'b0;
            low_ptr_q <= W'(N - 1);
        end else begin
            isr_q <= isr_next;
            if (wr_mask)
                mask_q <= bus_wdata[N-1:0];
            if (wr_cmd) begin
                if (bus_wdata[7])
                    base_q <= {bus_wdata[DW-1-W:0], {W{1'b0}}};
                else if (bus_wdata[7:3] == CMD_MODE_HI)
                    mode_q <= bus_wdata[2:0];
                else if (bus_wdata == CMD_SEL_IRR)
                    sel_isr_q <= 1'b0;
                else if (bus_wdata == CMD_SEL_ISR)
                    sel_isr_q <= 1'b1;
            end
            if (mode_q.rotate) begin
                if (ack_ok && mode_q.auto_eoi)
                    low_ptr_q <= cand;
                else if (eoi_do)
                    low_ptr_q <= eoi_line;
            end
        end
    end

    // Read-data register: acknowledge vector or status/mask read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (int_ack)
            bus_rdata <= base_q + (ack_ok ? DW'(cand) : DW'(N - 1));
        else if (rd_en)
            bus_rdata <= bus_addr ? DW'(mask_q) : DW'(sel_isr_q ? isr_q : irr_q);
    end
endmodule

// File: rtl/irq_ctl8_chk.sv
// Checker bound into irq_ctl8.
// It watches the mask, acknowledge, in-service and level-sensing rules on every clock.
module irq_ctl8_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic         int_ack,
    input logic         int_out,
    input logic [N-1:0] irq_in,
    input logic [N-1:0] irr,
    input logic [N-1:0] isr,
    input logic [N-1:0] mask,
    input logic         auto_eoi,
    input logic         level,
    input logic [7:0]   rdata
);
    logic rst_seen_q;

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q && rst_n)
            reset_state_chk: assert (isr == '0 && irr == '0 && mask == '0 && !int_out);
    end

    // R4
    masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr & ~mask));

    // R7
    spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out && !(bus_sel && bus_wr)) |=> $stable(isr));

    // R7
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out) |=> rdata[2:0] == 3'd7);

    // R10
    auto_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && auto_eoi && !(bus_sel && bus_wr)) |=> $stable(isr));

    // R5
    ack_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !auto_eoi && !(bus_sel && bus_wr))
        |=> $countones(isr) == $countones($past(isr)) + 1);

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level) && $past(rst_n)) |-> irr == $past(irq_in));
endmodule

bind irq_ctl8 irq_ctl8_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .int_ack(int_ack), .int_out(int_out), .irq_in(irq_in),
    .irr(irr_q), .isr(isr_q), .mask(mask_q), .auto_eoi(mode_q.auto_eoi),
    .level(mode_q.level), .rdata(bus_rdata)
);

// File: tb/sim_irq_ctl8.sv
// Scoreboard bench.
// Driver tasks push expected read/vector bytes into a queue.
// A monitor pops and compares them once the design has produced each byte.
module sim_irq_ctl8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       int_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    event got;

    always #4 clk = ~clk;   // 125 MHz

    irq_ctl8 u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .int_out(int_out),
        .int_ack(int_ack)
    );

    // Monitor: compare each produced byte against the oldest expectation.
    initial begin
        forever begin
            exp_t e;
            @(got);
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.val) begin
                errors++;
                $display("FAIL %s: rdata=%02h expected=%02h", e.tag, bus_rdata, e.val);
            end
        end
    end

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        exp_q.push_back('{exp, tag});
        ->got;
    endtask

    task automatic do_ack(input logic [7:0] exp, input string tag);
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        exp_q.push_back('{exp, tag});
        ->got;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic check_int(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (int_out !== exp) begin
            errors++;
            $display("FAIL %s: int_out=%0b expected=%0b", tag, int_out, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_int(1'b0, "R1");
        bus_read(1'b1, 8'h00, "R1 mask");
        bus_read(1'b0, 8'h00, "R1 pending");
        bus_write(1'b0, 8'h0B);
        bus_read(1'b0, 8'h00, "R1 in-service");
        // R2 edge capture, R6 vector with base 0, R8 select
        set_irq(8'h08);
        check_int(1'b1, "R2");
        bus_write(1'b0, 8'h0A);
        bus_read(1'b0, 8'h08, "R2 R8 pending");
        do_ack(8'h03, "R6");
        check_int(1'b0, "R2 steady level");
        bus_read(1'b0, 8'h00, "R2 cleared");
        bus_write(1'b0, 8'h0B);
        bus_read(1'b0, 8'h08, "R8 in-service");
        // R5 fixed nesting, R9 completions
        set_irq(8'h28);
        check_int(1'b0, "R5 lower blocked");
        set_irq(8'h2A);
        check_int(1'b1, "R5 higher nests");
        do_ack(8'h01, "R5 vector");
        bus_write(1'b0, 8'h20);
        bus_read(1'b0, 8'h08, "R9 nonspecific");
        check_int(1'b0, "R5 line5 below line3");
        bus_write(1'b0, 8'h63);
        check_int(1'b1, "R9 specific");
        do_ack(8'h05, "R5 vector line5");
        bus_write(1'b0, 8'h20);
        bus_read(1'b0, 8'h00, "R9 empty");
        set_irq(8'h00);
        // R4 mask, R6 base
        bus_write(1'b1, 8'h04);
        bus_read(1'b1, 8'h04, "R4 mask read");
        set_irq(8'h04);
        check_int(1'b0, "R4 masked");
        bus_write(1'b1, 8'h00);
        check_int(1'b1, "R4 unmasked");
        bus_write(1'b0, 8'hA5);
        do_ack(8'h2A, "R6 base");
        bus_write(1'b0, 8'h20);
        set_irq(8'h00);
        // R3 level mode, R7 spurious
        bus_write(1'b0, 8'h11);
        set_irq(8'h40);
        check_int(1'b1, "R3 level");
        set_irq(8'h00);
        do_ack(8'h2F, "R7 vector");
        bus_read(1'b0, 8'h00, "R7 in-service");
        set_irq(8'h10);
        check_int(1'b1, "R3 level 4");
        do_ack(8'h2C, "R3 vector");
        bus_write(1'b0, 8'h0A);
        bus_read(1'b0, 8'h10, "R3 not cleared");
        check_int(1'b0, "R5 equal rank");
        bus_write(1'b0, 8'h20);
        set_irq(8'h00);
        bus_read(1'b0, 8'h00, "R3 follows low");
        // R10 auto-completion
        bus_write(1'b0, 8'h12);
        set_irq(8'h04);
        do_ack(8'h2A, "R10 vector");
        bus_write(1'b0, 8'h0B);
        bus_read(1'b0, 8'h00, "R10 in-service");
        check_int(1'b0, "R10 no repeat");
        set_irq(8'h00);
        // R11 rotating priority
        bus_write(1'b0, 8'h14);
        set_irq(8'h42);
        do_ack(8'h29, "R11 initial order");
        bus_write(1'b0, 8'h20);
        set_irq(8'h40);
        set_irq(8'h41);
        do_ack(8'h2E, "R11 rotated");
        bus_write(1'b0, 8'h20);
        do_ack(8'h28, "R11 rotated again");
        bus_write(1'b0, 8'h20);
        bus_read(1'b0, 8'h00, "R11 in-service");
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule